// File: doc/BRIEF.md
# Dual-class host transmit buffer

This block is the transmit data store on the host side of a full-speed USB controller. Outbound payload is split into two traffic classes. Periodic traffic covers isochronous and interrupt transfers. Nonperiodic traffic covers control and bulk transfers. Each class owns one FIFO region and one request queue, and every OUT channel of that class shares them.

The two FIFO regions are carved out of a single word RAM. The periodic region starts at word 0 and its size comes from a configuration input. The nonperiodic region takes the words that remain. The application writes 32-bit payload words into a class and pushes request entries that each name a channel and a byte count.

Scheduling starts again at every frame-start pulse. The scheduler empties the periodic request queue first and only then serves the nonperiodic queue. For each request it issues, it streams ceil(bytes/4) words out on a plain valid/last transmit stream. For each class the block reports the free FIFO words and the free queue entries. It also raises a FIFO-empty interrupt, whose threshold can be set to half empty or fully empty, and sets a sticky flag when a push is dropped.

Top module: `dual_class_txbuf`

## Requirements
- R1: A payload push for a class is accepted only while that class's FIFO has a free word and its request queue has a free entry. An accepted push lowers that class's free-word count by one.
- R2: Each request queue holds 8 entries. A request push is accepted only while the queue is not full, and the free-entry output reports 8 minus the stored entries.
- R3: A dropped payload or request push sets that class's overflow flag, which stays set until reset. The dropped push leaves the stored words and the other class's flag untouched.
- R4: The class-select inputs use 1 for periodic and 0 for nonperiodic. The periodic FIFO size is `cfg_per_depth`, capped at TOTAL_WORDS, and the nonperiodic FIFO gets the rest. After reset, each class's free words equal its size and its free entries equal 8.
- R5: No word is transmitted until the first frame-start pulse after reset.
- R6: After a frame start, every queued periodic request is issued before any nonperiodic request. Nonperiodic service begins only once the periodic queue is empty.
- R7: If the periodic head request is waiting for its payload words, nonperiodic requests are not served. Periodic service resumes as soon as those words arrive.
- R8: An issued request sends ceil(bytes/4) words, in the order they were pushed, on consecutive cycles. Each word carries the channel and class of its request, and `tx_last` is high on the final word.
- R9: A request with a byte count of zero is retired without sending any word.
- R10: A frame start that arrives during a packet lets that packet finish, and periodic service then starts again.
- R11: When a class's level select is 1, its empty interrupt is high while free words times 2 is at least the class size. When the select is 0, the interrupt is high only while the class FIFO holds no word. The two classes are independent.
- R12: The free-word and free-entry outputs show the effect of a push or pop on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| cfg_per_depth | input | CW | Periodic region size in words (capped at TOTAL_WORDS) |
| cfg_per_half | input | 1 | Periodic empty interrupt threshold: 1 half, 0 fully |
| cfg_np_half | input | 1 | Nonperiodic empty interrupt threshold: 1 half, 0 fully |
| wr_valid | input | 1 | Payload word push |
| wr_class | input | 1 | Payload class: 1 periodic, 0 nonperiodic |
| wr_data | input | DATA_W | Payload word |
| rq_valid | input | 1 | Request entry push |
| rq_class | input | 1 | Request class: 1 periodic, 0 nonperiodic |
| rq_chan | input | CH_W | Channel number of the request |
| rq_bytes | input | BC_W | Byte count of the request |
| tx_valid | output | 1 | Transmit word valid |
| tx_class | output | 1 | Class of the word being sent |
| tx_chan | output | CH_W | Channel of the word being sent |
| tx_data | output | DATA_W | Transmit word |
| tx_last | output | 1 | Final word of the request |
| per_free_words | output | CW | Free words in the periodic FIFO |
| per_free_req | output | QCW | Free entries in the periodic request queue |
| np_free_words | output | CW | Free words in the nonperiodic FIFO |
| np_free_req | output | QCW | Free entries in the nonperiodic request queue |
| per_empty_irq | output | 1 | Periodic FIFO-empty interrupt |
| np_empty_irq | output | 1 | Nonperiodic FIFO-empty interrupt |
| per_ovf | output | 1 | Sticky periodic dropped-push flag |
| np_ovf | output | 1 | Sticky nonperiodic dropped-push flag |

## Verification
The assertions check several properties on every cycle. Pushes into a full FIFO or full queue must raise the overflow flag, and that flag must stay set. Both interrupts must agree with the free-word count under the selected threshold. Free counts may move by at most one step per cycle. Nothing may leave the block before the first frame start. Once a packet starts, its channel and class must stay steady until `tx_last`.

Some behaviour needs a known history and an expected data sequence, so only the directed scenarios can show it. That covers the periodic-first order across a frame, the stall behind a periodic head that lacks data, the retirement of zero-length requests, and a frame start landing in the middle of a packet. It also covers whether the words after an overflow still come out intact and in order.

// File: rtl/dual_class_txbuf_pkg.sv
package dual_class_txbuf_pkg;

  // Traffic class encoding used on every class-select input and on tx_class.
  typedef enum logic {
    CLS_NP  = 1'b0,
    CLS_PER = 1'b1
  } tx_class_e;

  // Scheduler phase within a frame.
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_PER  = 2'd1,
    PH_NP   = 2'd2
  } sched_phase_e;

endpackage

// File: rtl/txb_word_ram.sv
// Simple dual-port word store: one write port, one registered read port.
module txb_word_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/txb_req_queue.sv
// Small request queue held in registers; head is visible combinationally.
module txb_req_queue #(
  parameter int ENTRY_W = 15,
  parameter int DEPTH   = 8,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = PW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               nonempty,
  output logic               full,
  output logic [CW-1:0]      free
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0]      wp, rp;
  logic [CW-1:0]      count;
  logic               do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign free     = CW'(DEPTH) - count;
  assign head     = mem[rp];
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/txb_class_ctl.sv
// Pointer, occupancy and interrupt logic for one class region of the word RAM.
module txb_class_ctl #(
  parameter int TOTAL_WORDS = 64,
  localparam int AW         = $clog2(TOTAL_WORDS),
  localparam int CW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] depth,
  input  logic [AW-1:0] base,
  input  logic          push,
  input  logic          pop,
  input  logic          half_sel,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [CW-1:0] free,
  output logic          empty_irq
);

  logic [CW-1:0] wr_off, rd_off;
  logic          do_push, do_pop;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] off,
                                         input logic [CW-1:0] lim);
    return (off + CW'(1) >= lim) ? '0 : off + CW'(1);
  endfunction

  assign full      = (count >= depth);
  assign free      = full ? '0 : depth - count;
  assign do_push   = push && !full;
  assign do_pop    = pop && (count != '0);
  assign wr_addr   = base + wr_off[AW-1:0];
  assign rd_addr   = base + rd_off[AW-1:0];
  assign empty_irq = half_sel ? ({free, 1'b0} >= {1'b0, depth}) : (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_off <= step(wr_off, depth);
      if (do_pop)  rd_off <= step(rd_off, depth);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/txb_sched.sv
// Frame scheduler: periodic queue first, then nonperiodic; streams words out.
module txb_sched
  import dual_class_txbuf_pkg::*;
#(
  parameter int CH_W = 4,
  parameter int BC_W = 11,
  parameter int CW   = 7,
  localparam int WW  = BC_W - 1,
  localparam int MW  = (CW > WW) ? CW : WW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic [1:0]      q_nonempty,
  input  logic [CH_W-1:0] per_chan,
  input  logic [BC_W-1:0] per_bytes,
  input  logic [CH_W-1:0] np_chan,
  input  logic [BC_W-1:0] np_bytes,
  input  logic [CW-1:0]   per_count,
  input  logic [CW-1:0]   np_count,
  output logic [1:0]      q_pop,
  output logic [1:0]      d_pop,
  output logic            rd_cls,
  output logic            tx_valid,
  output logic            tx_class,
  output logic [CH_W-1:0] tx_chan,
  output logic            tx_last
);

  sched_phase_e    phase;
  tx_class_e       sel_cls, cur_cls;
  logic            busy, frame_pend, frame_hit, sel_valid, issue;
  logic [CH_W-1:0] sel_chan, cur_chan;
  logic [BC_W-1:0] sel_bytes;
  logic [BC_W:0]   byte_sum;
  logic [WW-1:0]   need, rem;
  logic [CW-1:0]   sel_count;

  always_comb begin
    sel_cls   = (phase == PH_PER) ? CLS_PER : CLS_NP;
    sel_valid = (sel_cls == CLS_PER) ? q_nonempty[1] : q_nonempty[0];
    sel_chan  = (sel_cls == CLS_PER) ? per_chan  : np_chan;
    sel_bytes = (sel_cls == CLS_PER) ? per_bytes : np_bytes;
    sel_count = (sel_cls == CLS_PER) ? per_count : np_count;
    byte_sum  = {1'b0, sel_bytes} + (BC_W + 1)'(3);
    need      = byte_sum[BC_W:2];
    frame_hit = frame_start || frame_pend;
    issue     = !busy && !frame_hit && (phase != PH_WAIT) && sel_valid &&
                (MW'(sel_count) >= MW'(need));
    q_pop     = issue ? ((sel_cls == CLS_PER) ? 2'b10 : 2'b01) : 2'b00;
    d_pop     = busy ? ((cur_cls == CLS_PER) ? 2'b10 : 2'b01) : 2'b00;
    rd_cls    = (cur_cls == CLS_PER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_WAIT;
      busy       <= 1'b0;
      frame_pend <= 1'b0;
      cur_cls    <= CLS_NP;
      cur_chan   <= '0;
      rem        <= '0;
      tx_valid   <= 1'b0;
      tx_class   <= 1'b0;
      tx_chan    <= '0;
      tx_last    <= 1'b0;
    end else begin
      tx_valid <= busy;
      tx_last  <= busy && (rem == WW'(1));
      tx_chan  <= cur_chan;
      tx_class <= (cur_cls == CLS_PER);
      if (busy) begin
        rem <= rem - WW'(1);
        if (rem == WW'(1)) busy <= 1'b0;
        if (frame_start) frame_pend <= 1'b1;
      end else if (frame_hit) begin
        phase      <= PH_PER;
        frame_pend <= 1'b0;
      end else if (phase == PH_PER && !q_nonempty[1]) begin
        phase <= PH_NP;
      end else if (issue) begin
        cur_cls  <= sel_cls;
        cur_chan <= sel_chan;
        if (need != '0) begin
          busy <= 1'b1;
          rem  <= need;
        end
      end
    end
  end

endmodule

// File: rtl/dual_class_txbuf.sv
module dual_class_txbuf
  import dual_class_txbuf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TOTAL_WORDS = 64,
  parameter int REQ_DEPTH   = 8,
  parameter int CH_W        = 4,
  parameter int BC_W        = 11,
  localparam int AW         = $clog2(TOTAL_WORDS),
  localparam int CW         = AW + 1,
  localparam int QCW        = $clog2(REQ_DEPTH) + 1,
  localparam int ENTRY_W    = CH_W + BC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [CW-1:0]     cfg_per_depth,
  input  logic              cfg_per_half,
  input  logic              cfg_np_half,
  input  logic              wr_valid,
  input  logic              wr_class,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rq_valid,
  input  logic              rq_class,
  input  logic [CH_W-1:0]   rq_chan,
  input  logic [BC_W-1:0]   rq_bytes,
  output logic              tx_valid,
  output logic              tx_class,
  output logic [CH_W-1:0]   tx_chan,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic [CW-1:0]     per_free_words,
  output logic [QCW-1:0]    per_free_req,
  output logic [CW-1:0]     np_free_words,
  output logic [QCW-1:0]    np_free_req,
  output logic              per_empty_irq,
  output logic              np_empty_irq,
  output logic              per_ovf,
  output logic              np_ovf
);

  // Index 1 is the periodic class, index 0 the nonperiodic class.
  logic [CW-1:0]      cls_depth [2];
  logic [AW-1:0]      cls_base  [2];
  logic [AW-1:0]      wr_addr_c [2];
  logic [AW-1:0]      rd_addr_c [2];
  logic [CW-1:0]      count_c   [2];
  logic [CW-1:0]      free_c    [2];
  logic [QCW-1:0]     qfree_c   [2];
  logic [ENTRY_W-1:0] head_c    [2];
  logic [1:0]         fifo_full, q_full, q_nonempty, irq_c, half_c;
  logic [1:0]         d_push, q_push, d_pop, q_pop, drop, ovf_q;
  logic [CW-1:0]      per_depth_c;
  logic               rd_cls;

  assign per_depth_c  = (cfg_per_depth > CW'(TOTAL_WORDS)) ? CW'(TOTAL_WORDS) : cfg_per_depth;
  assign cls_depth[1] = per_depth_c;
  assign cls_depth[0] = CW'(TOTAL_WORDS) - per_depth_c;
  assign cls_base[1]  = '0;
  assign cls_base[0]  = per_depth_c[AW-1:0];
  assign half_c       = {cfg_per_half, cfg_np_half};

  for (genvar g = 0; g < 2; g++) begin : g_cls
    assign d_push[g] = wr_valid && (wr_class == 1'(g)) && !fifo_full[g] && !q_full[g];
    assign q_push[g] = rq_valid && (rq_class == 1'(g)) && !q_full[g];
    assign drop[g]   = (wr_valid && (wr_class == 1'(g)) && !d_push[g]) ||
                       (rq_valid && (rq_class == 1'(g)) && !q_push[g]);

    txb_class_ctl #(.TOTAL_WORDS(TOTAL_WORDS)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .depth     (cls_depth[g]),
      .base      (cls_base[g]),
      .push      (d_push[g]),
      .pop       (d_pop[g]),
      .half_sel  (half_c[g]),
      .wr_addr   (wr_addr_c[g]),
      .rd_addr   (rd_addr_c[g]),
      .count     (count_c[g]),
      .full      (fifo_full[g]),
      .free      (free_c[g]),
      .empty_irq (irq_c[g])
    );

    txb_req_queue #(.ENTRY_W(ENTRY_W), .DEPTH(REQ_DEPTH)) u_q (
      .clk        (clk),
      .rst        (rst),
      .push       (q_push[g]),
      .push_entry ({rq_chan, rq_bytes}),
      .pop        (q_pop[g]),
      .head       (head_c[g]),
      .nonempty   (q_nonempty[g]),
      .full       (q_full[g]),
      .free       (qfree_c[g])
    );

    always_ff @(posedge clk) begin
      if (rst) ovf_q[g] <= 1'b0;
      else if (drop[g]) ovf_q[g] <= 1'b1;
    end
  end

  txb_word_ram #(.W(DATA_W), .DEPTH(TOTAL_WORDS)) u_ram (
    .clk   (clk),
    .we    (|d_push),
    .waddr (wr_class ? wr_addr_c[1] : wr_addr_c[0]),
    .wdata (wr_data),
    .re    (|d_pop),
    .raddr (rd_cls ? rd_addr_c[1] : rd_addr_c[0]),
    .rdata (tx_data)
  );

  txb_sched #(.CH_W(CH_W), .BC_W(BC_W), .CW(CW)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .q_nonempty  (q_nonempty),
    .per_chan    (head_c[1][ENTRY_W-1:BC_W]),
    .per_bytes   (head_c[1][BC_W-1:0]),
    .np_chan     (head_c[0][ENTRY_W-1:BC_W]),
    .np_bytes    (head_c[0][BC_W-1:0]),
    .per_count   (count_c[1]),
    .np_count    (count_c[0]),
    .q_pop       (q_pop),
    .d_pop       (d_pop),
    .rd_cls      (rd_cls),
    .tx_valid    (tx_valid),
    .tx_class    (tx_class),
    .tx_chan     (tx_chan),
    .tx_last     (tx_last)
  );

  assign per_free_words = free_c[1];
  assign np_free_words  = free_c[0];
  assign per_free_req   = qfree_c[1];
  assign np_free_req    = qfree_c[0];
  assign per_empty_irq  = irq_c[1];
  assign np_empty_irq   = irq_c[0];
  assign per_ovf        = ovf_q[1];
  assign np_ovf         = ovf_q[0];

endmodule

// File: rtl/dual_class_txbuf_chk.sv
module dual_class_txbuf_chk #(
  parameter int TOTAL_WORDS = 64,
  parameter int REQ_DEPTH   = 8,
  parameter int CW          = 7,
  parameter int QCW         = 4,
  parameter int CH_W        = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_start,
  input logic [CW-1:0]   cfg_per_depth,
  input logic            cfg_per_half,
  input logic            cfg_np_half,
  input logic            wr_valid,
  input logic            wr_class,
  input logic            rq_valid,
  input logic            rq_class,
  input logic            tx_valid,
  input logic            tx_class,
  input logic [CH_W-1:0] tx_chan,
  input logic            tx_last,
  input logic [CW-1:0]   per_free_words,
  input logic [QCW-1:0]  per_free_req,
  input logic [CW-1:0]   np_free_words,
  input logic [QCW-1:0]  np_free_req,
  input logic            per_empty_irq,
  input logic            np_empty_irq,
  input logic            per_ovf,
  input logic            np_ovf
);

  logic [CW-1:0] exp_per, exp_np;
  logic          seen_frame;

  always_comb begin
    exp_per = (cfg_per_depth > CW'(TOTAL_WORDS)) ? CW'(TOTAL_WORDS) : cfg_per_depth;
    exp_np  = CW'(TOTAL_WORDS) - exp_per;
  end

  always_ff @(posedge clk) begin
    if (rst) seen_frame <= 1'b0;
    else if (frame_start) seen_frame <= 1'b1;
  end

  a_r1_per_data_needs_queue: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_class && per_free_req == '0) |=> per_ovf);
  a_r1_np_data_needs_space: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_class && np_free_words == '0) |=> np_ovf);
  a_r2_np_req_full_drop: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_class && np_free_req == '0) |=> np_ovf);
  a_r2_req_bound: assert property (@(posedge clk) disable iff (rst)
    (per_free_req <= QCW'(REQ_DEPTH)) && (np_free_req <= QCW'(REQ_DEPTH)));
  a_r3_per_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    per_ovf |=> per_ovf);
  a_r3_np_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    np_ovf |=> np_ovf);
  a_r5_quiet_before_frame: assert property (@(posedge clk) disable iff (rst)
    !seen_frame |-> !tx_valid);
  a_r8_burst_steady: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_last) |=> (tx_valid && $stable(tx_chan) && $stable(tx_class)));
  a_r11_per_full_mode: assert property (@(posedge clk) disable iff (rst)
    !cfg_per_half |-> (per_empty_irq == (per_free_words == exp_per)));
  a_r11_np_full_mode: assert property (@(posedge clk) disable iff (rst)
    !cfg_np_half |-> (np_empty_irq == (np_free_words == exp_np)));
  a_r11_per_half_mode: assert property (@(posedge clk) disable iff (rst)
    (cfg_per_half && per_empty_irq) |-> ({per_free_words, 1'b0} >= {1'b0, exp_per}));
  a_r11_np_half_mode: assert property (@(posedge clk) disable iff (rst)
    (cfg_np_half && np_empty_irq) |-> ({np_free_words, 1'b0} >= {1'b0, exp_np}));
  a_r12_per_free_step: assert property (@(posedge clk) disable iff (rst)
    (per_free_words == $past(per_free_words)) ||
    (per_free_words == $past(per_free_words) + CW'(1)) ||
    (per_free_words == $past(per_free_words) - CW'(1)));
  a_r12_np_req_step: assert property (@(posedge clk) disable iff (rst)
    (np_free_req == $past(np_free_req)) ||
    (np_free_req == $past(np_free_req) + QCW'(1)) ||
    (np_free_req == $past(np_free_req) - QCW'(1)));

endmodule

bind dual_class_txbuf dual_class_txbuf_chk #(
  .TOTAL_WORDS(TOTAL_WORDS), .REQ_DEPTH(REQ_DEPTH), .CW(CW), .QCW(QCW), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .cfg_per_depth(cfg_per_depth),
  .cfg_per_half(cfg_per_half), .cfg_np_half(cfg_np_half), .wr_valid(wr_valid),
  .wr_class(wr_class), .rq_valid(rq_valid), .rq_class(rq_class), .tx_valid(tx_valid),
  .tx_class(tx_class), .tx_chan(tx_chan), .tx_last(tx_last),
  .per_free_words(per_free_words), .per_free_req(per_free_req),
  .np_free_words(np_free_words), .np_free_req(np_free_req),
  .per_empty_irq(per_empty_irq), .np_empty_irq(np_empty_irq),
  .per_ovf(per_ovf), .np_ovf(np_ovf)
);

// File: tb/dual_class_txbuf_bench.sv
`timescale 1ns/1ps
module dual_class_txbuf_bench;
  localparam int DATA_W = 32, TOTAL_WORDS = 64, REQ_DEPTH = 8, CH_W = 4, BC_W = 11;
  localparam int CW = $clog2(TOTAL_WORDS) + 1, QCW = $clog2(REQ_DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0;
  logic [CW-1:0] cfg_per_depth = CW'(32);
  logic cfg_per_half = 1'b1, cfg_np_half = 1'b1;
  logic wr_valid = 1'b0, wr_class = 1'b0, rq_valid = 1'b0, rq_class = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CH_W-1:0] rq_chan = '0;
  logic [BC_W-1:0] rq_bytes = '0;
  logic tx_valid, tx_class, tx_last, per_empty_irq, np_empty_irq, per_ovf, np_ovf;
  logic [CH_W-1:0] tx_chan;
  logic [DATA_W-1:0] tx_data;
  logic [CW-1:0] per_free_words, np_free_words;
  logic [QCW-1:0] per_free_req, np_free_req;

  dual_class_txbuf u_dual_class_txbuf (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0, cap_n = 0;
  logic [DATA_W-1:0] cap_data [128];
  logic [CH_W-1:0]   cap_chan [128];
  logic              cap_cls  [128];
  logic              cap_last [128];

  always @(negedge clk) begin
    if (!rst && tx_valid && cap_n < 128) begin
      cap_data[cap_n] = tx_data;
      cap_chan[cap_n] = tx_chan;
      cap_cls[cap_n]  = tx_class;
      cap_last[cap_n] = tx_last;
      cap_n++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int depth);
    cfg_per_depth = CW'(depth);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cap_n = 0;
  endtask

  task automatic push_word(input logic cls, input logic [31:0] d);
    wr_valid = 1'b1; wr_class = cls; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_req(input logic cls, input int ch, input int bytes);
    rq_valid = 1'b1; rq_class = cls; rq_chan = CH_W'(ch); rq_bytes = BC_W'(bytes);
    @(negedge clk);
    rq_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic expect_beat(input string req, input int i, input logic [31:0] d,
                             input int ch, input int cls, input int last);
    check(req, $sformatf("beat %0d data", i), int'(cap_data[i]), int'(d));
    check(req, $sformatf("beat %0d chan", i), int'(cap_chan[i]), ch);
    check(req, $sformatf("beat %0d class", i), int'(cap_cls[i]), cls);
    check(req, $sformatf("beat %0d last", i), int'(cap_last[i]), last);
  endtask

  // R4 R2 R11 R3: reset state and region sizing.
  task automatic t_reset();
    do_reset(32);
    check("R4", "per free words", int'(per_free_words), 32);
    check("R4", "np free words", int'(np_free_words), 32);
    check("R2", "per free req", int'(per_free_req), 8);
    check("R2", "np free req", int'(np_free_req), 8);
    check("R11", "irqs empty", int'({per_empty_irq, np_empty_irq}), 3);
    check("R3", "ovf clear", int'({per_ovf, np_ovf}), 0);
    do_reset(40);
    check("R4", "per words at 40", int'(per_free_words), 40);
    check("R4", "np words at 40", int'(np_free_words), 24);
    do_reset(100);
    check("R4", "per words capped", int'(per_free_words), 64);
    check("R4", "np words capped", int'(np_free_words), 0);
  endtask

  // R5 R6 R8 R9 R12 R1: periodic first, zero-length retired.
  task automatic t_order();
    do_reset(32);
    push_req(1'b0, 2, 8);
    push_word(1'b0, 32'h0A00_0000);
    check("R12", "np free after push", int'(np_free_words), 31);
    push_word(1'b0, 32'h0A00_0001);
    check("R1", "np free after 2 pushes", int'(np_free_words), 30);
    push_req(1'b1, 5, 5);
    push_word(1'b1, 32'h0B00_0000);
    push_word(1'b1, 32'h0B00_0001);
    push_req(1'b1, 6, 0);
    check("R12", "per free req", int'(per_free_req), 6);
    repeat (10) @(negedge clk);
    check("R5", "no tx before frame", cap_n, 0);
    pulse_frame();
    repeat (20) @(negedge clk);
    check("R9", "beats incl zero-length", cap_n, 4);
    expect_beat("R6", 0, 32'h0B00_0000, 5, 1, 0);
    expect_beat("R8", 1, 32'h0B00_0001, 5, 1, 1);
    expect_beat("R6", 2, 32'h0A00_0000, 2, 0, 0);
    expect_beat("R8", 3, 32'h0A00_0001, 2, 0, 1);
    check("R9", "per queue drained", int'(per_free_req), 8);
    check("R12", "np words back", int'(np_free_words), 32);
  endtask

  // R7: periodic head short of data blocks nonperiodic.
  task automatic t_block();
    cap_n = 0;
    push_req(1'b1, 1, 8);
    push_word(1'b1, 32'h0C00_0000);
    pulse_frame();
    push_req(1'b0, 3, 4);
    push_word(1'b0, 32'h0D00_0000);
    repeat (15) @(negedge clk);
    check("R7", "np held behind periodic", cap_n, 0);
    push_word(1'b1, 32'h0C00_0001);
    repeat (15) @(negedge clk);
    check("R7", "beats after release", cap_n, 3);
    expect_beat("R7", 0, 32'h0C00_0000, 1, 1, 0);
    expect_beat("R7", 1, 32'h0C00_0001, 1, 1, 1);
    expect_beat("R7", 2, 32'h0D00_0000, 3, 0, 1);
  endtask

  // R10: frame start during a nonperiodic burst.
  task automatic t_mid();
    cap_n = 0;
    push_req(1'b1, 7, 4);
    push_word(1'b1, 32'h0E00_0000);
    for (int i = 0; i < 4; i++) push_word(1'b0, 32'h0F00_0000 + i);
    push_req(1'b0, 4, 16);
    @(negedge clk);
    pulse_frame();
    repeat (20) @(negedge clk);
    check("R10", "beats", cap_n, 5);
    for (int i = 0; i < 4; i++)
      expect_beat("R10", i, 32'h0F00_0000 + i, 4, 0, (i == 3) ? 1 : 0);
    expect_beat("R10", 4, 32'h0E00_0000, 7, 1, 1);
  endtask

  // R1 R2 R3: dropped pushes and data integrity.
  task automatic t_ovf();
    do_reset(32);
    for (int i = 0; i < 8; i++) push_req(1'b0, 0, 64);
    check("R2", "np queue full", int'(np_free_req), 0);
    check("R3", "no drop yet", int'(np_ovf), 0);
    push_req(1'b0, 0, 64);
    check("R3", "np ovf set", int'(np_ovf), 1);
    check("R3", "per ovf untouched", int'(per_ovf), 0);
    check("R2", "np queue still full", int'(np_free_req), 0);
    push_word(1'b0, 32'h1111_1111);
    check("R1", "np data refused with queue full", int'(np_free_words), 32);
    for (int i = 0; i < 32; i++) push_word(1'b1, 32'h2000_0000 + i);
    check("R1", "per fifo full", int'(per_free_words), 0);
    check("R3", "per ovf before overflow", int'(per_ovf), 0);
    push_word(1'b1, 32'hDEAD_BEEF);
    check("R3", "per ovf set", int'(per_ovf), 1);
    repeat (3) @(negedge clk);
    check("R3", "per ovf sticky", int'(per_ovf), 1);
    push_req(1'b1, 9, 128);
    pulse_frame();
    repeat (50) @(negedge clk);
    check("R3", "beats", cap_n, 32);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++)
        if (cap_data[i] != 32'h2000_0000 + i || cap_last[i] != (i == 31)) bad++;
      check("R3", "stored words intact", bad, 0);
    end
  endtask

  // R11: threshold select per class.
  task automatic t_irq();
    cfg_per_half = 1'b1; cfg_np_half = 1'b0;
    do_reset(32);
    for (int i = 0; i < 16; i++) push_word(1'b1, i);
    check("R11", "per half at 16 free", int'(per_empty_irq), 1);
    push_word(1'b1, 32'h99);
    check("R11", "per half at 15 free", int'(per_empty_irq), 0);
    check("R11", "np full mode empty", int'(np_empty_irq), 1);
    push_word(1'b0, 32'h77);
    check("R11", "np full mode one word", int'(np_empty_irq), 0);
    cfg_np_half = 1'b1;
    @(negedge clk);
    check("R11", "np half mode 31 free", int'(np_empty_irq), 1);
    cfg_per_half = 1'b0;
    @(negedge clk);
    check("R11", "per full mode 17 words", int'(per_empty_irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_block();
    t_mid();
    t_ovf();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule